// File: doc/BRIEF.md
# Three-Level Cascading Timeout Wheel

This block keeps a small pool of countdown timers against an external tick whose period is the finest time unit (100 ms in the default sizing). Time is held as three dials: a fine dial of 10 positions counting ticks, a middle dial of 60 positions counting seconds, and a coarse dial of 5 positions counting minutes. The middle dial steps only on the tick that wraps the fine dial, and the coarse dial steps only when the middle dial also wraps. Any timeout from one unit up to the full five-minute span is reached with 75 slot positions in all.

A started timer computes its absolute deadline as three digits. It is parked on the coarsest dial whose digit differs from the present time. When that dial steps onto the parked digit, the timer drops one level, keeping the finer digits it still has to wait for. A timer with nothing left below expires at once, and otherwise it expires only when the fine dial reaches its last digit. Expiring timers report their number on an output strobe, one per clock cycle. Commands carry a timer number; an illegal timeout raises an error pulse.

Top module: `tcw_cascade_wheel`

## Requirements
- R1: After reset, `expire_valid_o` and `err_o` are low and stay low until a timer has been started and has run out.
- R2: A start with `timeout_i` = t, 1 <= t <= 3000, in a cycle without a tick makes timer `id_i` report on the t-th tick after the start. The report appears in the cycle after that tick, with `expire_valid_o` high and `expire_id_o` equal to the timer number.
- R3: Timeouts that are whole seconds or whole minutes, where every finer digit of the deadline is zero, report on the exact tick at which the coarser dial reaches the deadline. They are not reinserted with a zero remainder.
- R4: A timeout of exactly 3000 units reports after one full turn of all three dials, on the 3000th tick, and not at once.
- R5: A start with t = 0 or t > 3000 arms nothing and leaves any running timer of that number unchanged. It raises `err_o` for exactly the following cycle.
- R6: A cancel (`cancel_i` high) stops timer `id_i` so it never reports, and it also withdraws a report for that timer that is waiting to be emitted. When `start_i` and `cancel_i` are both high, the cancel wins.
- R7: Starting a timer that is already running replaces its deadline with the new one and withdraws any report waiting for it.
- R8: When several timers run out on the same tick, they are reported one per cycle on consecutive cycles in ascending timer number.
- R9: A tick in the same cycle as a start is not counted, so a timer started there with timeout t reports on the t-th later tick.
- R10: The middle dial advances only on a tick while the fine dial holds its last position, and the coarse dial advances only when both lower dials hold their last positions. Timers that cross second and minute boundaries therefore keep exact deadlines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse per finest time unit |
| start_i | input | 1 | Arm timer `id_i` with `timeout_i` |
| cancel_i | input | 1 | Stop timer `id_i` |
| id_i | input | 3 | Timer number for the command |
| timeout_i | input | 12 | Timeout in finest units, legal 1..3000 |
| err_o | output | 1 | Illegal timeout pulse, one cycle after the start |
| expire_valid_o | output | 1 | An expiry is being reported this cycle |
| expire_id_o | output | 3 | Number of the expiring timer |

## Verification
The stimulus mixes short timeouts that stay on the fine dial, whole-second and whole-minute values whose lower digits are zero, full-span 3000-unit values, and arbitrary values across the whole range. Short values check fine-dial placement. Whole-unit values tell a correct immediate expiry on cascade apart from a spurious extra reinsertion. Arbitrary long values, started at varying dial phases, expose any off-by-one in the carry between dials or in the deadline arithmetic. Same-tick pairs, starts that coincide with a tick, restarts, cancels of waiting reports and out-of-range values check the ordering of reports, the tick-counting convention, re-arming, withdrawal of reports and rejection of bad values.

// File: rtl/tcw_pkg.sv
package tcw_pkg;

  typedef enum logic [1:0] {
    LVL_FINE   = 2'd0,
    LVL_MID    = 2'd1,
    LVL_COARSE = 2'd2
  } wheel_lvl_e;

  // Absolute position in finest units from the three dial digits.
  function automatic int units_of(int coarse, int mid, int fine, int n_fine, int n_mid);
    return coarse * n_fine * n_mid + mid * n_fine + fine;
  endfunction

  function automatic int digit_fine(int units, int n_fine);
    return units % n_fine;
  endfunction

  function automatic int digit_mid(int units, int n_fine, int n_mid);
    return (units / n_fine) % n_mid;
  endfunction

  function automatic int digit_coarse(int units, int n_fine, int n_mid);
    return units / (n_fine * n_mid);
  endfunction

endpackage

// File: rtl/tcw_dials.sv
module tcw_dials #(
  parameter int L0 = 10,
  parameter int L1 = 60,
  parameter int L2 = 5,
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  output logic [SW-1:0] cur0,
  output logic [SW-1:0] cur1,
  output logic [SW-1:0] cur2,
  output logic [SW-1:0] nxt0,
  output logic [SW-1:0] nxt1,
  output logic [SW-1:0] nxt2,
  output logic          step1,
  output logic          step2
);

  function automatic logic [SW-1:0] inc_wrap(logic [SW-1:0] v, int lim);
    return (int'(v) == lim - 1) ? '0 : v + 1'b1;
  endfunction

  always_comb begin
    step1 = tick_i && (cur0 == SW'(L0 - 1));
    step2 = step1 && (cur1 == SW'(L1 - 1));
    nxt0  = tick_i ? inc_wrap(cur0, L0) : cur0;
    nxt1  = step1  ? inc_wrap(cur1, L1) : cur1;
    nxt2  = step2  ? inc_wrap(cur2, L2) : cur2;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur0 <= '0;
      cur1 <= '0;
      cur2 <= '0;
    end else begin
      cur0 <= nxt0;
      cur1 <= nxt1;
      cur2 <= nxt2;
    end
  end

endmodule

// File: rtl/tcw_entry.sv
module tcw_entry
  import tcw_pkg::*;
#(
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          step1_i,
  input  logic          step2_i,
  input  logic [SW-1:0] nxt0_i,
  input  logic [SW-1:0] nxt1_i,
  input  logic [SW-1:0] nxt2_i,
  input  logic          load_i,
  input  logic          kill_i,
  input  wheel_lvl_e    load_lvl_i,
  input  logic [SW-1:0] load_slot_i,
  input  logic [SW-1:0] load_mid_i,
  input  logic [SW-1:0] load_fine_i,
  output logic          expire_o
);

  logic          act_q, act_n;
  wheel_lvl_e    lvl_q, lvl_n;
  logic [SW-1:0] slot_q, slot_n, mid_q, mid_n, fine_q, fine_n;

  always_comb begin
    act_n    = act_q;
    lvl_n    = lvl_q;
    slot_n   = slot_q;
    mid_n    = mid_q;
    fine_n   = fine_q;
    expire_o = 1'b0;
    if (kill_i) begin
      act_n = 1'b0;
    end else if (load_i) begin
      act_n  = 1'b1;
      lvl_n  = load_lvl_i;
      slot_n = load_slot_i;
      mid_n  = load_mid_i;
      fine_n = load_fine_i;
    end else if (act_q && tick_i) begin
      unique case (lvl_q)
        LVL_COARSE: if (step2_i && slot_q == nxt2_i) begin
          if (mid_q == '0 && fine_q == '0) begin
            expire_o = 1'b1;
            act_n    = 1'b0;
          end else if (mid_q != '0) begin
            lvl_n  = LVL_MID;
            slot_n = mid_q;
          end else begin
            lvl_n  = LVL_FINE;
            slot_n = fine_q;
          end
        end
        LVL_MID: if (step1_i && slot_q == nxt1_i) begin
          if (fine_q == '0) begin
            expire_o = 1'b1;
            act_n    = 1'b0;
          end else begin
            lvl_n  = LVL_FINE;
            slot_n = fine_q;
          end
        end
        default: if (slot_q == nxt0_i) begin
          expire_o = 1'b1;
          act_n    = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      lvl_q  <= LVL_FINE;
      slot_q <= '0;
      mid_q  <= '0;
      fine_q <= '0;
    end else begin
      act_q  <= act_n;
      lvl_q  <= lvl_n;
      slot_q <= slot_n;
      mid_q  <= mid_n;
      fine_q <= fine_n;
    end
  end

endmodule

// File: rtl/tcw_drain.sv
module tcw_drain #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  set_i,
  input  logic [N-1:0]  clr_i,
  output logic          valid_o,
  output logic [IW-1:0] id_o
);

  logic [N-1:0] pend_q, grant;

  always_comb begin
    grant = '0;
    id_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        id_o     = IW'(i);
      end
    end
    valid_o = |pend_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~grant & ~clr_i) | set_i;
  end

endmodule

// File: rtl/tcw_cascade_wheel.sv
module tcw_cascade_wheel
  import tcw_pkg::*;
#(
  parameter int SLOTS_FINE   = 10,
  parameter int SLOTS_MID    = 60,
  parameter int SLOTS_COARSE = 5,
  parameter int NUM_TIMERS   = 8,
  localparam int SPAN = SLOTS_FINE * SLOTS_MID * SLOTS_COARSE,
  localparam int TW   = $clog2(SPAN + 1),
  localparam int IW   = $clog2(NUM_TIMERS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          start_i,
  input  logic          cancel_i,
  input  logic [IW-1:0] id_i,
  input  logic [TW-1:0] timeout_i,
  output logic          err_o,
  output logic          expire_valid_o,
  output logic [IW-1:0] expire_id_o
);

  localparam int MAXL = (SLOTS_MID > SLOTS_FINE)
                      ? ((SLOTS_MID > SLOTS_COARSE) ? SLOTS_MID : SLOTS_COARSE)
                      : ((SLOTS_FINE > SLOTS_COARSE) ? SLOTS_FINE : SLOTS_COARSE);
  localparam int SW = $clog2(MAXL);

  logic [SW-1:0] dial0_q, dial1_q, dial2_q, nxt0, nxt1, nxt2;
  logic          step1, step2;

  tcw_dials #(.L0(SLOTS_FINE), .L1(SLOTS_MID), .L2(SLOTS_COARSE), .SW(SW)) dials_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .cur0(dial0_q), .cur1(dial1_q), .cur2(dial2_q),
    .nxt0(nxt0), .nxt1(nxt1), .nxt2(nxt2),
    .step1(step1), .step2(step2)
  );

  // Placement of a new timer relative to the time it starts counting from.
  logic [SW-1:0] b0, b1, b2, e0, e1, e2, ld_slot;
  wheel_lvl_e    ld_lvl;
  logic          start_ok, start_bad;
  int            base_u, exp_u;

  always_comb begin
    b0        = tick_i ? nxt0 : dial0_q;
    b1        = tick_i ? nxt1 : dial1_q;
    b2        = tick_i ? nxt2 : dial2_q;
    base_u    = units_of(int'(b2), int'(b1), int'(b0), SLOTS_FINE, SLOTS_MID);
    exp_u     = (base_u + int'(timeout_i)) % SPAN;
    e0        = SW'(digit_fine(exp_u, SLOTS_FINE));
    e1        = SW'(digit_mid(exp_u, SLOTS_FINE, SLOTS_MID));
    e2        = SW'(digit_coarse(exp_u, SLOTS_FINE, SLOTS_MID));
    start_bad = (timeout_i == '0) || (int'(timeout_i) > SPAN);
    start_ok  = start_i && !cancel_i && !start_bad;
    if (int'(timeout_i) < SPAN && e2 == b2 && exp_u > base_u) begin
      if (e1 == b1) begin
        ld_lvl  = LVL_FINE;
        ld_slot = e0;
      end else begin
        ld_lvl  = LVL_MID;
        ld_slot = e1;
      end
    end else begin
      ld_lvl  = LVL_COARSE;
      ld_slot = e2;
    end
  end

  logic [NUM_TIMERS-1:0] expire_vec, clr_vec;
  logic                  expire_any;

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_entry
    logic hit;
    assign hit        = (id_i == IW'(g));
    assign clr_vec[g] = hit && (cancel_i || start_ok);

    tcw_entry #(.SW(SW)) entry_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .step1_i(step1), .step2_i(step2),
      .nxt0_i(nxt0), .nxt1_i(nxt1), .nxt2_i(nxt2),
      .load_i(hit && start_ok), .kill_i(hit && cancel_i),
      .load_lvl_i(ld_lvl), .load_slot_i(ld_slot),
      .load_mid_i(e1), .load_fine_i(e0),
      .expire_o(expire_vec[g])
    );
  end

  assign expire_any = |expire_vec;

  tcw_drain #(.N(NUM_TIMERS), .IW(IW)) drain_i (
    .clk(clk), .rst_n(rst_n), .set_i(expire_vec), .clr_i(clr_vec),
    .valid_o(expire_valid_o), .id_o(expire_id_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_o <= 1'b0;
    else        err_o <= start_i && !cancel_i && start_bad;
  end

endmodule

// File: rtl/tcw_cascade_wheel_chk.sv
module tcw_cascade_wheel_chk #(
  parameter int L0 = 10,
  parameter int L1 = 60,
  parameter int SW = 6,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_i,
  input logic          start_i,
  input logic          cancel_i,
  input logic [IW-1:0] id_i,
  input logic          err_o,
  input logic          expire_valid_o,
  input logic [IW-1:0] expire_id_o,
  input logic [SW-1:0] dial0_q,
  input logic [SW-1:0] dial1_q,
  input logic [SW-1:0] dial2_q,
  input logic          expire_any
);

  assert_mid_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dial1_q != $past(dial1_q)) |-> $past(tick_i && dial0_q == SW'(L0 - 1)));

  assert_coarse_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dial2_q != $past(dial2_q)) |->
      $past(tick_i && dial0_q == SW'(L0 - 1) && dial1_q == SW'(L1 - 1)));

  assert_expire_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    expire_any |-> tick_i);

  assert_err_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(start_i && !cancel_i));

  assert_cancel_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cancel_i) |-> !(expire_valid_o && expire_id_o == $past(id_i)));

  assert_ascending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_valid_o && $past(expire_valid_o) && !$past(tick_i))
      |-> (expire_id_o > $past(expire_id_o)));

endmodule

bind tcw_cascade_wheel tcw_cascade_wheel_chk #(
  .L0(SLOTS_FINE), .L1(SLOTS_MID), .SW(SW), .IW(IW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .start_i(start_i),
  .cancel_i(cancel_i), .id_i(id_i), .err_o(err_o),
  .expire_valid_o(expire_valid_o), .expire_id_o(expire_id_o),
  .dial0_q(dial0_q), .dial1_q(dial1_q), .dial2_q(dial2_q),
  .expire_any(expire_any)
);

// File: tb/tcw_cascade_wheel_tb_top.sv
`timescale 1ns/1ps
module tcw_cascade_wheel_tb_top;

  localparam int N        = 8;
  localparam int IW       = 3;
  localparam int TW       = 12;
  localparam int SPAN     = 3000;
  localparam int TICK_GAP = 12;
  localparam int RUN_CYC  = 96000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick, start, cancel;
  logic [IW-1:0] id;
  logic [TW-1:0] tmo;
  logic          err, ev;
  logic [IW-1:0] eid;

  always #4 clk = ~clk;

  tcw_cascade_wheel dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .start_i(start), .cancel_i(cancel),
    .id_i(id), .timeout_i(tmo), .err_o(err), .expire_valid_o(ev), .expire_id_o(eid)
  );

  int     n_chk, n_fail;
  bit     done;
  bit     mact[N];
  int     mdl[N];
  string  mkind[N];
  bit [N-1:0] mpend, np, touched;
  bit     experr, ok, dtick, dstart, dcancel;
  int     tickcnt, did, dt, lo, g, r, k;
  string  tag;

  task automatic chk(input bit pass, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!pass) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lowest(input bit [N-1:0] p);
    for (int i = 0; i < N; i++) if (p[i]) return i;
    return -1;
  endfunction

  function automatic int rand_timeout();
    int c;
    c = int'($urandom % 5);
    case (c)
      0:       return 1 + int'($urandom % 20);
      1:       return 10 * (1 + int'($urandom % 300));
      2:       return 600 * (1 + int'($urandom % 5));
      3:       return 1 + int'($urandom % 3000);
      default: return ($urandom % 2) ? 0 : 3001 + int'($urandom % 1000);
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5eed_0042));
    tick = 0; start = 0; cancel = 0; id = '0; tmo = '0;
    for (int i = 0; i < N; i++) begin mact[i] = 0; mdl[i] = 0; mkind[i] = "R2"; end
    mpend = '0; experr = 0; tickcnt = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < RUN_CYC && !done; c++) begin
      @(negedge clk);
      // Compare outputs against the model state for this cycle.
      lo = lowest(mpend);
      if (lo < 0) begin
        tag = (c < 8) ? "R1" : "R6";
        chk(!ev, tag, "unexpected expiry", int'(ev), 0);
      end else begin
        tag = ($countones(mpend) > 1) ? "R8" : mkind[lo];
        chk(ev && int'(eid) == lo, tag, "expiry id", ev ? int'(eid) : -1, lo);
      end
      tag = (c < 8) ? "R1" : "R5";
      chk(err == experr, tag, "error pulse", int'(err), int'(experr));

      // Stimulus: directed corner cases first, random traffic later.
      dtick = (c > 0) && (c % TICK_GAP == 0);
      dstart = 0; dcancel = 0; did = 0; dt = 0;
      case (c)
        13:  begin dstart = 1; did = 0; dt = 3000; end  // R4 full span
        14:  begin dstart = 1; did = 1; dt = 600;  end  // R3 whole minute
        15:  begin dstart = 1; did = 2; dt = 10;   end  // R3 whole second
        24:  begin dstart = 1; did = 3; dt = 1;    end  // R9 start on tick
        25:  begin dstart = 1; did = 4; dt = 5;    end
        40:  begin dcancel = 1; did = 4;           end  // R6 cancel running
        26:  begin dstart = 1; did = 5; dt = 50;   end
        50:  begin dstart = 1; did = 5; dt = 7;    end  // R7 restart
        27:  begin dstart = 1; did = 6; dt = 3;    end  // R8 pair
        28:  begin dstart = 1; did = 7; dt = 3;    end
        75:  begin dstart = 1; did = 6; dt = 2;    end
        76:  begin dstart = 1; did = 7; dt = 2;    end
        97:  begin dcancel = 1; did = 7;           end  // R6 cancel waiting report
        100: begin dstart = 1; did = 3; dt = 0;    end  // R5 zero
        101: begin dstart = 1; did = 3; dt = 3001; end  // R5 too large
        102: begin dstart = 1; did = 3; dt = 4;    end
        default: ;
      endcase
      if (c >= 200) begin
        r = int'($urandom % 100);
        if (r < 12) begin
          dstart = 1; did = 2 + int'($urandom % 6); dt = rand_timeout();
          if (r == 0) dcancel = 1;  // R6 cancel beats start
        end else if (r < 16) begin
          dcancel = 1; did = 2 + int'($urandom % 6);
        end
      end
      tick = dtick; start = dstart; cancel = dcancel; id = IW'(did); tmo = TW'(dt);

      // Model update for the coming clock edge.
      np = mpend;
      g = lowest(mpend);
      if (g >= 0) np[g] = 0;
      ok = dstart && !dcancel && dt > 0 && dt <= SPAN;
      touched = '0;
      if (dcancel || ok) touched[did] = 1;
      if (dtick) begin
        tickcnt++;
        for (int i = 0; i < N; i++)
          if (mact[i] && !touched[i] && mdl[i] == tickcnt) begin
            np[i] = 1; mact[i] = 0;
          end
      end
      if (dcancel) begin
        mact[did] = 0; np[did] = 0;
      end else if (ok) begin
        if (mact[did])          mkind[did] = "R7";
        else if (dtick)         mkind[did] = "R9";
        else if (dt == SPAN)    mkind[did] = "R4";
        else if (dt % 10 == 0)  mkind[did] = "R3";
        else if (dt >= 600)     mkind[did] = "R10";
        else                    mkind[did] = "R2";
        mact[did] = 1; mdl[did] = tickcnt + dt; np[did] = 0;
      end
      experr = dstart && !dcancel && !ok;
      mpend = np;
    end
    k = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * (RUN_CYC + 2000));
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule